// File: doc/BRIEF.md
# Event Timer and Watchdog with Shared Prescaler

The block contains an 8-bit up-counting event timer and an 8-bit watchdog that share a single divide-by-2^n prescaler. At any time only one of the two owns the prescaler. The other counts its input events undivided. The timer counts either internal instruction cycles or transitions on an external clock pin. The pin is re-timed by sampling it twice per instruction cycle, and either its rising or its falling edge is selected. One instruction cycle spans `PHASES` oscillator clocks.

Software drives the block through a small write port that has three addresses: the timer value, the control byte and the overflow flag. A separate strobe clears the watchdog. The timer value and the control byte can be read back on output ports. The prescaler count itself is hidden, and it can only be reset, as a side effect of owner-specific actions.

Top module: `tw_timer_wdog`

## Requirements
- R1: After reset the control byte reads 0xFF, the timer reads 0x00, and the overflow flag and the watchdog timeout are both 0.
- R2: The control byte is written at address 1. Its bit 5 is the source (1 = pin, 0 = instruction cycle), bit 4 is the pin edge, bit 3 is the owner (1 = watchdog, 0 = timer) and bits 2:0 are the rate code. With source 0 and owner 1, the timer advances by one per instruction cycle (4 clocks by default).
- R3: With owner 0, the timer advances once per 2^(code+1) source events, so codes 0 to 7 give ratios from 1:2 to 1:256.
- R4: With source 1, the timer counts rising pin edges when bit 4 is 0 and falling pin edges when bit 4 is 1.
- R5: The pin is sampled at two points per instruction cycle. A pin that stays high for 2 clocks and then low for 2 clocks is counted once per pulse.
- R6: A write to address 0 loads the timer on the next edge. When the timer owns the prescaler, the write also zeroes the prescaler. A load that coincides with an increment wins over the increment.
- R7: The overflow flag sets when the timer steps from 0xFF to 0x00. It stays set until a write to address 2 with data bit 0 equal to 0. An overflow in the same cycle as that write leaves the flag set.
- R8: With owner 0, the watchdog counts instruction cycles. On its 256th step after a clear, it wraps and pulses the timeout output high for exactly one cycle.
- R9: With owner 1, the watchdog steps once per 2^code instruction cycles, and the timer runs at 1:1.
- R10: The watchdog clear strobe zeroes the watchdog counter, and it also zeroes the prescaler when the watchdog owns it. A clear that coincides with the wrap suppresses the pulse. With owner 0, the strobe leaves the prescaler count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 timer, 1 control, 2 overflow flag |
| wr_data | input | 8 | Write data |
| wdt_clr | input | 1 | Watchdog clear strobe |
| ext_clk_pin | input | 1 | External count pin, asynchronous |
| tmr_count | output | 8 | Current timer value |
| ctrl_q | output | 8 | Control byte readback |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Two overflow-flag events can fall in the same clock: the timer can step from 0xFF to 0x00 in the very cycle that software writes 0 to the flag address. The bench loads 0xFF at a known phase of the instruction cycle and then times the flag-clear write to land on the edge where that step occurs. The flag must read 1 afterwards and must then fall on a later clear. Two similar collisions are provoked the same way, by counting clocks since reset: a watchdog clear that lands on the wrap edge must leave the timeout low, and a timer load that lands on an increment edge must hold the loaded value.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int REG_W   = 8;
  localparam int PRE_W   = 8;
  localparam int SHIFT_W = $clog2(PRE_W) + 1;

  localparam logic [1:0] ADDR_TMR  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef struct packed {
    logic [1:0] spare;
    logic       src_pin;
    logic       edge_fall;
    logic       own_wdt;
    logic [2:0] rate;
  } tw_ctrl_t;

  // divide exponent when the timer owns the prescaler: 2^(code+1)
  function automatic logic [SHIFT_W-1:0] tmr_shift(input logic [2:0] code);
    return SHIFT_W'(code) + SHIFT_W'(1);
  endfunction

  // divide exponent when the watchdog owns the prescaler: 2^code
  function automatic logic [SHIFT_W-1:0] wdt_shift(input logic [2:0] code);
    return SHIFT_W'(code);
  endfunction

  // true when the low 'sh' bits of the count are all ones
  function automatic logic div_hit(input logic [PRE_W-1:0] cnt,
                                   input logic [SHIFT_W-1:0] sh);
    logic [PRE_W:0] mask;
    mask = ((PRE_W+1)'(1) << sh) - (PRE_W+1)'(1);
    return (cnt & mask[PRE_W-1:0]) == mask[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/tw_phase_sync.sv
module tw_phase_sync #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_pin,
  output logic cyc_tick,
  output logic ext_rise,
  output logic ext_fall
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] SAMP_A = PH_W'(1);
  localparam logic [PH_W-1:0] SAMP_B = PH_W'(PHASES / 2 + 1);
  localparam logic [PH_W-1:0] LAST   = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phase;
  logic meta, smp, smp_d;
  logic smp_en;

  assign smp_en   = (phase == SAMP_A) || (phase == SAMP_B);
  assign cyc_tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      meta  <= 1'b0;
      smp   <= 1'b0;
      smp_d <= 1'b0;
    end else begin
      phase <= (phase == LAST) ? '0 : phase + PH_W'(1);
      meta  <= ext_pin;
      if (smp_en) smp <= meta;
      smp_d <= smp;
    end
  end

  assign ext_rise = smp & ~smp_d;
  assign ext_fall = ~smp & smp_d;
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_evt,
  input  logic               clr,
  input  logic [SHIFT_W-1:0] shift,
  output logic               out_evt
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (in_evt) cnt <= cnt + PRE_W'(1);
  end

  assign out_evt = in_evt && !clr && div_hit(cnt, shift);
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clr,
  output logic wrap,
  output logic timeout
);
  logic [WDT_W-1:0] cnt;

  assign wrap = step && !clr && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= wrap;
      if (clr)       cnt <= '0;
      else if (step) cnt <= cnt + WDT_W'(1);
    end
  end
endmodule

// File: rtl/tw_timer_wdog.sv
module tw_timer_wdog
  import tw_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int WDT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wdt_clr,
  input  logic             ext_clk_pin,
  output logic [REG_W-1:0] tmr_count,
  output logic [REG_W-1:0] ctrl_q,
  output logic             tmr_ovf,
  output logic             wdt_timeout
);
  tw_ctrl_t ctrl;
  logic [REG_W-1:0] tmr_r;
  logic ovf_r;

  logic cyc_tick, ext_rise, ext_fall;
  logic wr_tmr, wr_ctrl, wr_flag;
  logic src_evt, pre_in, pre_clr, pre_out;
  logic tmr_step, wdt_step, tmr_wrap, wdt_wrap;
  logic [SHIFT_W-1:0] pre_shift;

  assign wr_tmr  = wr_en && (wr_addr == ADDR_TMR);
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);

  tw_phase_sync #(.PHASES(PHASES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .ext_pin  (ext_clk_pin),
    .cyc_tick (cyc_tick),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall)
  );

  // timer source selection
  assign src_evt = ctrl.src_pin ? (ctrl.edge_fall ? ext_fall : ext_rise) : cyc_tick;

  // prescaler routing by owner
  assign pre_in    = ctrl.own_wdt ? cyc_tick : src_evt;
  assign pre_clr   = ctrl.own_wdt ? wdt_clr  : wr_tmr;
  assign pre_shift = ctrl.own_wdt ? wdt_shift(ctrl.rate) : tmr_shift(ctrl.rate);
  assign tmr_step  = ctrl.own_wdt ? src_evt  : pre_out;
  assign wdt_step  = ctrl.own_wdt ? pre_out  : cyc_tick;

  tw_prescaler u_pre (
    .clk     (clk),
    .rst     (rst),
    .in_evt  (pre_in),
    .clr     (pre_clr),
    .shift   (pre_shift),
    .out_evt (pre_out)
  );

  tw_wdog #(.WDT_W(WDT_W)) u_wdt (
    .clk     (clk),
    .rst     (rst),
    .step    (wdt_step),
    .clr     (wdt_clr),
    .wrap    (wdt_wrap),
    .timeout (wdt_timeout)
  );

  assign tmr_wrap = tmr_step && !wr_tmr && (tmr_r == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= tw_ctrl_t'('1);
      tmr_r <= '0;
      ovf_r <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= tw_ctrl_t'(wr_data);
      if (wr_tmr)        tmr_r <= wr_data;
      else if (tmr_step) tmr_r <= tmr_r + REG_W'(1);
      if (tmr_wrap)      ovf_r <= 1'b1;
      else if (wr_flag)  ovf_r <= wr_data[0];
    end
  end

  assign tmr_count = tmr_r;
  assign ctrl_q    = REG_W'(ctrl);
  assign tmr_ovf   = ovf_r;
endmodule

// File: rtl/tw_timer_wdog_chk.sv
module tw_timer_wdog_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_tmr,
  input logic       wr_flag,
  input logic [7:0] wr_data,
  input logic [7:0] tmr_count,
  input logic       tmr_ovf,
  input logic       tmr_wrap,
  input logic       wdt_clr,
  input logic       wdt_timeout,
  input logic       pre_in,
  input logic       pre_out,
  input logic       ext_rise,
  input logic       ext_fall
);
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    wr_tmr |=> tmr_count == $past(wr_data));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    !wr_tmr |=> (tmr_count == $past(tmr_count)) || (tmr_count == $past(tmr_count) + 8'd1));

  a_r7_set_on_wrap: assert property (@(posedge clk) disable iff (rst)
    tmr_wrap |=> tmr_ovf);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (tmr_ovf && !(wr_flag && !wr_data[0])) |=> tmr_ovf);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !wdt_timeout);

  a_r10_clr_blocks: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |=> !wdt_timeout);

  a_r3_out_needs_in: assert property (@(posedge clk) disable iff (rst)
    pre_out |-> pre_in);

  a_r5_edge_spacing: assert property (@(posedge clk) disable iff (rst)
    (ext_rise || ext_fall) |=> !(ext_rise || ext_fall));
endmodule

bind tw_timer_wdog tw_timer_wdog_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_tmr      (wr_tmr),
  .wr_flag     (wr_flag),
  .wr_data     (wr_data),
  .tmr_count   (tmr_count),
  .tmr_ovf     (tmr_ovf),
  .tmr_wrap    (tmr_wrap),
  .wdt_clr     (wdt_clr),
  .wdt_timeout (wdt_timeout),
  .pre_in      (pre_in),
  .pre_out     (pre_out),
  .ext_rise    (ext_rise),
  .ext_fall    (ext_fall)
);

// File: tb/tb_tw_timer_wdog.sv
module tb_tw_timer_wdog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic wdt_clr = 1'b0;
  logic ext_clk_pin = 1'b0;
  logic [7:0] tmr_count, ctrl_q;
  logic tmr_ovf, wdt_timeout;

  int checks = 0;
  int errors = 0;
  int k = 0;        // posedges since reset release
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  tw_timer_wdog dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_clr(wdt_clr), .ext_clk_pin(ext_clk_pin), .tmr_count(tmr_count),
    .ctrl_q(ctrl_q), .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst) k <= k + 1;
  end

  initial begin
    wait (cycles > 150000);
    errors = errors + 1;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // {ctrl, load, instr cycles, expected count, expected flag}
  localparam int NV = 7;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {8'h08, 8'h10, 16'd20,  8'h24, 1'b0},   // R2 1:1
    {8'h00, 8'h00, 16'd20,  8'h0A, 1'b0},   // R3 1:2
    {8'h02, 8'h05, 16'd40,  8'h0A, 1'b0},   // R3 1:8
    {8'h07, 8'h00, 16'd600, 8'h02, 1'b0},   // R3 1:256
    {8'h08, 8'hF8, 16'd10,  8'h02, 1'b1},   // R7 wrap, R2
    {8'h03, 8'hFF, 16'd33,  8'h01, 1'b1},   // R3 1:16 with wrap
    {8'h0F, 8'h80, 16'd16,  8'h90, 1'b0}    // R9 timer 1:1 when watchdog owns
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // load timer so the write lands on a posedge with k%4 == ph
  task automatic tmr_load_at(input logic [7:0] d, input int ph);
    @(negedge clk);
    while ((k % 4) != ((ph + 3) % 4)) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wclr_at(input int ph);
    @(negedge clk);
    while ((k % 4) != ((ph + 3) % 4)) @(negedge clk);
    wdt_clr = 1'b1;
    @(negedge clk);
    wdt_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ctrl", 16'(ctrl_q), 16'hFF);
    check("R1 count", 16'(tmr_count), 16'h00);
    check("R1 flag", 16'(tmr_ovf), 16'h0);
    check("R1 timeout", 16'(wdt_timeout), 16'h0);

    // vector table: R2, R3, R6 (prescaler clear on load), R7, R9
    for (int i = 0; i < NV; i++) begin
      reg_write(2'd2, 8'h00);
      reg_write(2'd1, VEC[i][40:33]);
      tmr_load_at(VEC[i][32:25], 1);
      repeat (4 * int'(VEC[i][24:9]) - 1) @(negedge clk);
      check($sformatf("R2/R3/R9 vec%0d count", i), 16'(tmr_count), 16'(VEC[i][8:1]));
      check($sformatf("R7 vec%0d flag", i), 16'(tmr_ovf), 16'(VEC[i][0]));
    end

    // R4: edge select
    for (int m = 0; m < 2; m++) begin
      ext_clk_pin = 1'b0;
      reg_write(2'd1, (m == 0) ? 8'h28 : 8'h38);
      repeat (8) @(negedge clk);
      reg_write(2'd0, 8'h00);
      ext_clk_pin = 1'b1;
      repeat (10) @(negedge clk);
      check($sformatf("R4 mode%0d after rise", m), 16'(tmr_count), (m == 0) ? 16'd1 : 16'd0);
      ext_clk_pin = 1'b0;
      repeat (10) @(negedge clk);
      check($sformatf("R4 mode%0d after fall", m), 16'(tmr_count), 16'd1);
    end

    // R5: minimum-width pulses, 2 high 2 low
    reg_write(2'd1, 8'h28);
    reg_write(2'd0, 8'h00);
    for (int p = 0; p < 5; p++) begin
      ext_clk_pin = 1'b1; repeat (2) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check("R5 narrow pulses", 16'(tmr_count), 16'd5);

    // R6: load coincides with increment
    reg_write(2'd1, 8'h08);
    tmr_load_at(8'h40, 0);
    check("R6 load beats increment", 16'(tmr_count), 16'h40);

    // R10: watchdog clear leaves timer-owned prescaler alone (1:4)
    reg_write(2'd1, 8'h01);
    tmr_load_at(8'h00, 1);
    repeat (7) @(negedge clk);
    wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    repeat (7) @(negedge clk);
    check("R10 prescaler kept", 16'(tmr_count), 16'd1);

    // R7: overflow and flag clear in the same cycle
    reg_write(2'd1, 8'h08);
    reg_write(2'd2, 8'h00);
    tmr_load_at(8'hFF, 1);
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 set wins count", 16'(tmr_count), 16'h00);
    check("R7 set wins flag", 16'(tmr_ovf), 16'h1);
    reg_write(2'd2, 8'h00);
    check("R7 later clear", 16'(tmr_ovf), 16'h0);

    // R8: watchdog undivided, wraps at 256 instruction cycles
    reg_write(2'd1, 8'h00);
    wclr_at(1);
    repeat (1022) @(negedge clk);
    check("R8 before wrap", 16'(wdt_timeout), 16'h0);
    @(negedge clk);
    check("R8 pulse", 16'(wdt_timeout), 16'h1);
    @(negedge clk);
    check("R8 pulse width", 16'(wdt_timeout), 16'h0);

    // R10: clear lands on wrap edge
    wclr_at(1);
    repeat (1022) @(negedge clk);
    wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    check("R10 clear suppresses pulse", 16'(wdt_timeout), 16'h0);

    // R9: watchdog owns prescaler at 1:2, clear zeroes it
    reg_write(2'd1, 8'h09);
    wclr_at(1);
    repeat (2046) @(negedge clk);
    check("R9 before wrap", 16'(wdt_timeout), 16'h0);
    @(negedge clk);
    check("R9 pulse", 16'(wdt_timeout), 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule